// File: doc/BRIEF.md
# Registered Read-Only Memory with Configurable Control Pin

This block is a read-only memory of 8192 bytes. A pipeline register sits on its output and is loaded on every rising clock edge. The address may change as soon as an edge has passed, and the visible data stays put until the following edge. This lets the next access be decoded while the current word is still being used, as in a pipelined microsequencer.

One control input, `ctl`, has its role fixed at elaboration by a configuration byte. It can be an output enable that acts at once, an output enable that acts on the clock, or an asynchronous initialize. The initialize loads a programmable word into the pipeline register. The output-enable flag stands in for a tri-state driver, and the data bus reads zero while the flag is low.

The memory contents are produced from the address and a seed parameter, so the array needs no storage. The initialize word and the configuration byte are also parameters.

Top module: `regprom_top`

## Requirements
- R1: While no initialize is in force, each rising clock edge loads the register with the byte at `addr`. That byte is `((addr[7:0] ^ addr[12:5]) + SEED) mod 256`, and SEED defaults to 0x3C.
- R2: An address change made after a rising edge leaves `dout` unchanged until the next rising edge.
- R3: The role of `ctl` is set by CFG. 0x01 selects clocked enable and 0x02 selects initialize. 0x00, which is the default, selects immediate enable, and so does every other value.
- R4: In immediate-enable mode, `dout_en` is the inverse of `ctl` and follows it without waiting for a clock edge.
- R5: In clocked-enable mode, `ctl` is sampled on each rising edge. A sampled HIGH clears `dout_en` and a sampled LOW sets it. Between edges, `dout_en` keeps its value.
- R6: In initialize mode, `dout_en` is always 1. A LOW on `ctl` puts INIT_WORD into the register at once, without a clock edge.
- R7: In initialize mode, rising edges do not change the register while `ctl` is LOW. Clocked loading resumes at the first rising edge after `ctl` returns HIGH.
- R8: With the default INIT_WORD of 0x00, an initialize clears the register to all zeros.
- R9: `dout` is 0 whenever `dout_en` is 0.
- R10: While `rst_n` is low, the register is zero and the clocked-enable flop is in the disabled state. Internal release of reset follows the deassertion of `rst_n` after two rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| addr | input | 13 | Read address |
| ctl | input | 1 | Shared control pin; its role is set by CFG |
| dout | output | 8 | Registered data, forced to 0 while disabled |
| dout_en | output | 1 | Output-enable flag (stands in for a tri-state drive) |

## Verification
The hardest case to reach from the ports is an initialize that is asserted between clock edges and held across an edge while the address moves. The register must show the initialize word at once, ignore the edge, and then pick up the new address on the first edge after release. The bench pulls `ctl` low a few nanoseconds after a falling edge, changes the address, lets a full edge pass and samples just after it. It then releases `ctl` away from any edge and checks the two phases separately. The clocked-enable case is approached the same way: the bench probes `dout_en` both just before and just after the edge that follows a change on `ctl`.

// File: rtl/regprom_pkg.sv
package regprom_pkg;

  typedef enum logic [1:0] {
    ROLE_AOE  = 2'd0,
    ROLE_SOE  = 2'd1,
    ROLE_INIT = 2'd2
  } role_e;

  // Configuration byte to control-pin role; unknown codes fall back to immediate enable.
  function automatic role_e decode_role(input logic [7:0] cfg);
    case (cfg)
      8'h01:   return ROLE_SOE;
      8'h02:   return ROLE_INIT;
      default: return ROLE_AOE;
    endcase
  endfunction

endpackage

// File: rtl/regprom_rstsync.sv
module regprom_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign srst_n = sh_q[STAGES-1];
endmodule

// File: rtl/regprom_array.sv
module regprom_array #(
  parameter int                ADDR_W = 13,
  parameter int                DATA_W = 8,
  parameter logic [DATA_W-1:0] SEED   = 8'h3C
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data
);
  logic [DATA_W-1:0] lo_bits;
  logic [DATA_W-1:0] hi_bits;

  // Contents are a pure function of the address, so no storage is elaborated.
  always_comb begin
    lo_bits = addr[DATA_W-1:0];
    hi_bits = addr[ADDR_W-1 -: DATA_W];
    data    = (lo_bits ^ hi_bits) + SEED;
  end
endmodule

// File: rtl/regprom_oe.sv
module regprom_oe
  import regprom_pkg::*;
#(
  parameter role_e ROLE = ROLE_AOE
) (
  input  logic clk,
  input  logic srst_n,
  input  logic ctl,
  output logic oe
);
  logic se_q;
  logic se_d;
  logic se_en;

  always_comb begin
    se_en = (ROLE == ROLE_SOE);
    se_d  = ~ctl;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)    se_q <= 1'b0;
    else if (se_en) se_q <= se_d;
  end

  always_comb begin
    case (ROLE)
      ROLE_SOE:  oe = se_q;
      ROLE_INIT: oe = 1'b1;
      default:   oe = ~ctl;
    endcase
  end
endmodule

// File: rtl/regprom_pipe.sv
module regprom_pipe #(
  parameter int                DATA_W    = 8,
  parameter logic [DATA_W-1:0] INIT_WORD = '0,
  parameter bit                USE_INIT  = 1'b0
) (
  input  logic              clk,
  input  logic              srst_n,
  input  logic              ctl,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);
  logic init_n;
  logic cap_en;

  always_comb begin
    init_n = ctl | ~USE_INIT;
    cap_en = init_n;
  end

  // Initialize acts asynchronously and also blocks clocked capture while held low.
  always_ff @(posedge clk or negedge srst_n or negedge init_n) begin
    if (!srst_n)      q <= '0;
    else if (!init_n) q <= INIT_WORD;
    else if (cap_en)  q <= d;
  end
endmodule

// File: rtl/regprom_top.sv
module regprom_top
  import regprom_pkg::*;
#(
  parameter int                ADDR_W    = 13,
  parameter int                DATA_W    = 8,
  parameter logic [DATA_W-1:0] SEED      = 8'h3C,
  parameter logic [DATA_W-1:0] INIT_WORD = '0,
  parameter logic [7:0]        CFG       = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ctl,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);
  localparam role_e ROLE     = decode_role(CFG);
  localparam bit    USE_INIT = (ROLE == ROLE_INIT);

  logic              srst_n;
  logic [DATA_W-1:0] rom_data;
  logic [DATA_W-1:0] pipe_q;
  logic              oe;

  regprom_rstsync #(.STAGES(2)) i_rstsync (
    .clk   (clk),
    .rst_n (rst_n),
    .srst_n(srst_n)
  );

  regprom_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEED(SEED)) i_array (
    .addr(addr),
    .data(rom_data)
  );

  regprom_pipe #(.DATA_W(DATA_W), .INIT_WORD(INIT_WORD), .USE_INIT(USE_INIT)) i_pipe (
    .clk   (clk),
    .srst_n(srst_n),
    .ctl   (ctl),
    .d     (rom_data),
    .q     (pipe_q)
  );

  regprom_oe #(.ROLE(ROLE)) i_oe (
    .clk   (clk),
    .srst_n(srst_n),
    .ctl   (ctl),
    .oe    (oe)
  );

  always_comb begin
    dout_en = oe;
    dout    = oe ? pipe_q : '0;
  end
endmodule

// File: rtl/regprom_chk.sv
module regprom_chk
  import regprom_pkg::*;
#(
  parameter int                ADDR_W    = 13,
  parameter int                DATA_W    = 8,
  parameter logic [DATA_W-1:0] SEED      = 8'h3C,
  parameter logic [DATA_W-1:0] INIT_WORD = '0,
  parameter logic [7:0]        CFG       = 8'h00
) (
  input logic              clk,
  input logic              srst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              ctl,
  input logic [DATA_W-1:0] q,
  input logic [DATA_W-1:0] dout,
  input logic              dout_en
);
  localparam role_e ROLE    = decode_role(CFG);
  localparam bit    IS_INIT = (ROLE == ROLE_INIT);
  localparam bit    IS_SOE  = (ROLE == ROLE_SOE);
  localparam bit    IS_AOE  = (ROLE == ROLE_AOE);

  function automatic logic [DATA_W-1:0] want_byte(input logic [ADDR_W-1:0] a);
    logic [DATA_W-1:0] x;
    x = a[DATA_W-1:0] ^ a[ADDR_W-1 -: DATA_W];
    return x + SEED;
  endfunction

  p_capture_r1: assert property (@(posedge clk) disable iff (!srst_n)
    (!IS_INIT || ctl) |=> ((IS_INIT && !ctl) || (q == want_byte($past(addr)))));

  p_async_follow_r4: assert property (@(posedge clk) disable iff (!srst_n)
    IS_AOE |-> (dout_en == !ctl));

  p_sync_off_r5: assert property (@(posedge clk) disable iff (!srst_n)
    (IS_SOE && ctl) |=> !dout_en);

  p_sync_on_r5: assert property (@(posedge clk) disable iff (!srst_n)
    (IS_SOE && !ctl) |=> dout_en);

  p_init_load_r6: assert property (@(posedge clk) disable iff (!srst_n)
    (IS_INIT && !ctl) |-> (q == INIT_WORD));

  p_init_enabled_r6: assert property (@(posedge clk) disable iff (!srst_n)
    IS_INIT |-> dout_en);

  p_gate_zero_r9: assert property (@(posedge clk) disable iff (!srst_n)
    !dout_en |-> (dout == '0));
endmodule

bind regprom_top regprom_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEED(SEED), .INIT_WORD(INIT_WORD), .CFG(CFG)
) i_chk (
  .clk    (clk),
  .srst_n (srst_n),
  .addr   (addr),
  .ctl    (ctl),
  .q      (pipe_q),
  .dout   (dout),
  .dout_en(dout_en)
);

// File: tb/test_regprom_top.sv
module test_regprom_top;
  logic        clk;
  logic        rst_n;
  logic [12:0] addr;
  logic        ctl_a, ctl_s, ctl_i, ctl_z, ctl_x;
  logic [7:0]  do_a, do_s, do_i, do_z, do_x;
  logic        en_a, en_s, en_i, en_z, en_x;
  int          n_chk;
  int          n_fail;
  bit          done;

  regprom_top i_regprom_top (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ctl(ctl_a), .dout(do_a), .dout_en(en_a));
  regprom_top #(.CFG(8'h01)) i_regprom_top_sync (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ctl(ctl_s), .dout(do_s), .dout_en(en_s));
  regprom_top #(.CFG(8'h02), .INIT_WORD(8'hA5)) i_regprom_top_init (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ctl(ctl_i), .dout(do_i), .dout_en(en_i));
  regprom_top #(.CFG(8'h02)) i_regprom_top_clr (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ctl(ctl_z), .dout(do_z), .dout_en(en_z));
  regprom_top #(.CFG(8'h5C)) i_regprom_top_odd (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ctl(ctl_x), .dout(do_x), .dout_en(en_x));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [7:0] rom_ref(input logic [12:0] a);
    logic [7:0] x;
    x = a[7:0] ^ a[12:5];
    return x + 8'h3C;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; addr = '0;
    ctl_a = 1'b0; ctl_s = 1'b0; ctl_i = 1'b1; ctl_z = 1'b1; ctl_x = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10", "async dout in reset", do_a, 0);
    check("R10", "sync enable in reset", en_s, 0);
    check("R10", "init dout in reset", do_i, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R5", "sync enabled after ctl low", en_s, 1);
  endtask

  task automatic t_capture();
    logic [12:0] pts [4] = '{13'h0000, 13'h1FFF, 13'h0ABC, 13'h1234};
    foreach (pts[k]) begin
      @(negedge clk) addr = pts[k];
      @(posedge clk); #2 addr = pts[k] ^ 13'h1555;
      @(negedge clk);
      check("R2", "hold after addr change", do_a, rom_ref(pts[k]));
      @(negedge clk);
      check("R1", "capture", do_a, rom_ref(pts[k] ^ 13'h1555));
    end
  endtask

  task automatic t_async();
    @(negedge clk) ctl_a = 1'b1; ctl_x = 1'b1;
    #1;
    check("R4", "immediate disable", en_a, 0);
    check("R9", "zero while disabled", do_a, 0);
    check("R3", "odd cfg acts as immediate", en_x, 0);
    @(negedge clk);
    check("R4", "stays disabled", en_a, 0);
    ctl_a = 1'b0; ctl_x = 1'b0;
    #1;
    check("R4", "immediate enable", en_a, 1);
    check("R4", "data back", do_a, rom_ref(addr));
    check("R3", "odd cfg data back", do_x, rom_ref(addr));
  endtask

  task automatic t_sync();
    @(negedge clk) addr = 13'h0777; ctl_s = 1'b1;
    #1;
    check("R5", "still enabled before edge", en_s, 1);
    @(posedge clk); #1;
    check("R5", "disabled after edge", en_s, 0);
    check("R9", "sync zero while disabled", do_s, 0);
    @(negedge clk) ctl_s = 1'b0;
    #1;
    check("R5", "still disabled before edge", en_s, 0);
    @(posedge clk); #1;
    check("R5", "enabled after edge", en_s, 1);
    check("R5", "data after enable", do_s, rom_ref(13'h0777));
  endtask

  task automatic t_init();
    @(negedge clk) addr = 13'h0421;
    @(negedge clk);
    check("R1", "init mode capture", do_i, rom_ref(13'h0421));
    #3 ctl_i = 1'b0; ctl_z = 1'b0;
    #1;
    check("R6", "immediate init word", do_i, 8'hA5);
    check("R6", "always enabled", en_i, 1);
    check("R8", "default init clears", do_z, 0);
    addr = 13'h1B0F;
    @(posedge clk); #1;
    check("R7", "edge ignored while low", do_i, 8'hA5);
    check("R8", "clear held", do_z, 0);
    @(negedge clk) ctl_i = 1'b1; ctl_z = 1'b1;
    #1;
    check("R7", "no load on release", do_i, 8'hA5);
    @(posedge clk); #1;
    check("R7", "resumes after release", do_i, rom_ref(13'h1B0F));
    check("R7", "clear instance resumes", do_z, rom_ref(13'h1B0F));
  endtask

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    t_reset();
    t_capture();
    t_async();
    t_sync();
    t_init();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule